// File: doc/BRIEF.md
# SIMD Pixel Pack and Merge Unit

This block formats fixed-point pixel data for a graphics datapath. Each operation takes two 64-bit source operands and a 5-bit scale taken from a graphics status register. There are five operations. Two of them reduce wide signed fixed-point lanes to unsigned bytes. One reduces 32-bit lanes to saturated signed 16-bit values. One widens bytes into 16-bit fixed-point lanes. The last interleaves the bytes of two 32-bit sources.

Every pack operation works the same way on each lane. The lane is shifted left by the scale. It is then shifted right arithmetically by an amount set by the format, which places the binary point. Finally it is clamped to the output range. The left shift is done at 64 bits, so no bit is lost before the clamp.

The result is registered. A request presented with `validIn` produces its result one cycle later, marked by `validOut`. A 32-bit result sits in the low half of `result`, and the upper half is zero.

Top module: `pixfmt_unit`

## Requirements
- R1: While `rstN` is low, `validOut`, `illegalOp` and `result` are all zero.
- R2: `validOut` is high exactly one cycle after a cycle with `validIn` high. `result` loads only when `validIn` is high and holds its value otherwise.
- R3: `scaleIn` carries status register bits 7:3. The 16-to-8 pack uses only `scaleIn[3:0]` and ignores `scaleIn[4]`. The other packs use all five bits.
- R4: Select 0 (pack16) treats each 16-bit lane i of `srcB` as signed. The lane is shifted left by the scale, then arithmetically right by 7, and clamped to 0..255. The result is placed in byte i of `result[31:0]`, with `result[63:32]` zero.
- R5: Select 1 (pack32) produces a full 64-bit result. For each word i, bits 31:8 take `srcA[32i+23:32i]`. Bits 7:0 take the signed word i of `srcB`, shifted left by the scale, arithmetically right by 23, and clamped to 0..255.
- R6: Select 2 (fixed pack) treats each 32-bit word i of `srcB` as signed. The word is shifted left by the scale, arithmetically right by 16, and saturated to -32768..32767. The 16-bit result goes to `result[16i+15:16i]`, and `result[63:32]` is zero.
- R7: Select 3 (expand) takes byte i of `srcB[31:0]`, zero-extends it and shifts it left by 4. The value is placed in 16-bit lane i, so bits 3:0 and 15:12 of every lane are zero.
- R8: Select 4 (merge) builds `result` from the low 32 bits of both sources. Result byte 2k is byte k of `srcB`, and result byte 2k+1 is byte k of `srcA`.
- R9: Selects 5, 6 and 7 are illegal. An accepted illegal request gives `result` zero and raises `illegalOp` together with `validOut`. `illegalOp` is low in every other cycle.
- R10: No bits are lost in the left shift. With the maximum scale, any positive nonzero lane saturates high and any negative lane saturates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Request strobe |
| opSel | input | 3 | Operation select (0..4 legal) |
| scaleIn | input | 5 | Scale field, status register bits 7:3 |
| srcA | input | 64 | First source operand |
| srcB | input | 64 | Second source operand |
| validOut | output | 1 | Result valid, one cycle after request |
| illegalOp | output | 1 | Accepted request had an unused select |
| result | output | 64 | Formatted result |

## Verification
The hardest situations to reach are the clamp boundaries under a large scale. Random operands almost always saturate, so they rarely land exactly on 255, 0, -32768 or 32767, and they seldom show bits shifted beyond 32 bits. The stimulus therefore includes directed lanes placed just inside and just outside each clamp limit. It also includes small positive and small negative lanes at scale 31, and a scale with bit 4 set to confirm that pack16 ignores that bit. Random requests with gaps in `validIn` exercise the hold behaviour of the output register in between.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int WIDE_W = 64;

  typedef enum logic [2:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pixOp_e;

  typedef struct packed {
    logic load;
    logic pack16;
    logic pack32;
    logic packFix;
    logic expand;
    logic merge;
    logic bad;
  } opStrobe_t;

  function automatic logic [7:0] satU8(input logic signed [WIDE_W-1:0] v);
    if (v < 0)                          return 8'h00;
    else if (v > WIDE_W'(signed'(255))) return 8'hff;
    else                                return v[7:0];
  endfunction

  function automatic logic [15:0] satS16(input logic signed [WIDE_W-1:0] v);
    if (v < -WIDE_W'(signed'(32768)))     return 16'h8000;
    else if (v > WIDE_W'(signed'(32767))) return 16'h7fff;
    else                                  return v[15:0];
  endfunction
endpackage

// File: rtl/pixfmt_ctrl.sv
module pixfmt_ctrl
  import pixfmt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      validIn,
  input  logic [2:0] opSel,
  output opStrobe_t strb,
  output logic      validOut,
  output logic      illegalOp
);
  always_comb begin
    strb      = '0;
    strb.load = validIn;
    case (opSel)
      OP_PACK16:  strb.pack16  = 1'b1;
      OP_PACK32:  strb.pack32  = 1'b1;
      OP_PACKFIX: strb.packFix = 1'b1;
      OP_EXPAND:  strb.expand  = 1'b1;
      OP_MERGE:   strb.merge   = 1'b1;
      default:    strb.bad     = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      validOut  <= validIn;
      illegalOp <= validIn & strb.bad;
    end
  end
endmodule

// File: rtl/pixfmt_dp.sv
module pixfmt_dp
  import pixfmt_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int HALF_W   = 16,
  parameter int WORD_W   = 32,
  parameter int SCALE_W  = 5,
  parameter int FRAC_P16 = 7,
  parameter int FRAC_P32 = 23,
  parameter int FRAC_FIX = 16,
  parameter int EXP_SH   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  opStrobe_t          strb,
  input  logic [WIDE_W-1:0]  srcA,
  input  logic [WIDE_W-1:0]  srcB,
  input  logic [SCALE_W-1:0] scale,
  output logic [WIDE_W-1:0]  result
);
  localparam int N_HALF  = WIDE_W / HALF_W;
  localparam int N_WORD  = WIDE_W / WORD_W;
  localparam int N_NARROW = WORD_W / PIX_W;
  localparam int KEEP_W  = WORD_W - PIX_W;
  localparam int PAD_W   = HALF_W - PIX_W - EXP_SH;

  logic [WORD_W-1:0] p16Res;
  logic [WIDE_W-1:0] p32Res;
  logic [WORD_W-1:0] fixRes;
  logic [WIDE_W-1:0] expRes;
  logic [WIDE_W-1:0] mrgRes;
  logic [WIDE_W-1:0] nextRes;
  logic unusedHiA;

  assign unusedHiA = ^{srcA[WORD_W-1:KEEP_W], srcA[WIDE_W-1:WIDE_W-PIX_W]};

  for (genvar i = 0; i < N_HALF; i++) begin : g_pack16
    logic signed [WIDE_W-1:0] ext, shl;
    assign ext = {{(WIDE_W-HALF_W){srcB[i*HALF_W+HALF_W-1]}}, srcB[i*HALF_W +: HALF_W]};
    assign shl = ext <<< scale[SCALE_W-2:0];
    assign p16Res[i*PIX_W +: PIX_W] = satU8(shl >>> FRAC_P16);
  end

  for (genvar i = 0; i < N_WORD; i++) begin : g_word
    logic signed [WIDE_W-1:0] ext, shl;
    assign ext = {{(WIDE_W-WORD_W){srcB[i*WORD_W+WORD_W-1]}}, srcB[i*WORD_W +: WORD_W]};
    assign shl = ext <<< scale;
    assign p32Res[i*WORD_W +: WORD_W] = {srcA[i*WORD_W +: KEEP_W], satU8(shl >>> FRAC_P32)};
    assign fixRes[i*HALF_W +: HALF_W] = satS16(shl >>> FRAC_FIX);
  end

  for (genvar i = 0; i < N_NARROW; i++) begin : g_byte
    assign expRes[i*HALF_W +: HALF_W] = {{PAD_W{1'b0}}, srcB[i*PIX_W +: PIX_W], {EXP_SH{1'b0}}};
    assign mrgRes[i*HALF_W +: HALF_W] = {srcA[i*PIX_W +: PIX_W], srcB[i*PIX_W +: PIX_W]};
  end

  always_comb begin
    nextRes = ({WIDE_W{strb.pack16}}  & {{(WIDE_W-WORD_W){1'b0}}, p16Res})
            | ({WIDE_W{strb.pack32}}  & p32Res)
            | ({WIDE_W{strb.packFix}} & {{(WIDE_W-WORD_W){1'b0}}, fixRes})
            | ({WIDE_W{strb.expand}}  & expRes)
            | ({WIDE_W{strb.merge}}   & mrgRes);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          result <= '0;
    else if (strb.load) result <= nextRes;
  end
endmodule

// File: rtl/pixfmt_unit.sv
module pixfmt_unit
  import pixfmt_pkg::*;
#(
  parameter int SCALE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic [2:0]         opSel,
  input  logic [SCALE_W-1:0] scaleIn,
  input  logic [63:0]        srcA,
  input  logic [63:0]        srcB,
  output logic               validOut,
  output logic               illegalOp,
  output logic [63:0]        result
);
  opStrobe_t strb;

  pixfmt_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel),
    .strb(strb), .validOut(validOut), .illegalOp(illegalOp)
  );

  pixfmt_dp #(.SCALE_W(SCALE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcA(srcA), .srcB(srcB),
    .scale(scaleIn), .result(result)
  );
endmodule

// File: rtl/pixfmt_checker.sv
module pixfmt_checker (
  input logic        clk,
  input logic        rstN,
  input logic        validIn,
  input logic [2:0]  opSel,
  input logic [63:0] srcA,
  input logic [63:0] srcB,
  input logic        validOut,
  input logic        illegalOp,
  input logic [63:0] result
);
  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(result) && !validOut));
  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (validOut && result == 64'd0));
  // R4
  pack16_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd0) |=> (result[63:32] == 32'd0 && !illegalOp));
  // R6
  fix_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd2) |=> result[63:32] == 32'd0);
  // R7
  expand_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd3) |=> (result & 64'hf00ff00ff00ff00f) == 64'd0);
  // R8
  merge_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd4) |=> (result[7:0] == $past(srcB[7:0]) &&
                                    result[63:56] == $past(srcA[31:24])));
  // R5
  pack32_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd1) |=> result[31:8] == $past(srcA[23:0]));
endmodule

bind pixfmt_unit pixfmt_checker i_chk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel), .srcA(srcA),
  .srcB(srcB), .validOut(validOut), .illegalOp(illegalOp), .result(result)
);

// File: tb/test_pixfmt_unit.sv
module test_pixfmt_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic        validIn = 0;
  logic [2:0]  opSel = 0;
  logic [4:0]  scaleIn = 0;
  logic [63:0] srcA = 0, srcB = 0;
  logic        validOut, illegalOp;
  logic [63:0] result;

  int vectors = 0, miscompares = 0;
  logic [63:0] expRes = 0;
  logic expValid = 0, expIll = 0;
  string tag = "";
  bit done = 0;

  always #4 clk = ~clk;

  pixfmt_unit i_pixfmt_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel), .scaleIn(scaleIn),
    .srcA(srcA), .srcB(srcB), .validOut(validOut), .illegalOp(illegalOp), .result(result)
  );

  function automatic longint clampL(longint v, longint lo, longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic [4:0] sc);
    logic [63:0] r = 0;
    case (op)
      3'd0: for (int i = 0; i < 4; i++) begin
              shortint h = b[i*16 +: 16];
              longint s = h;
              r[i*8 +: 8] = 8'(clampL((s <<< (sc & 5'd15)) >>> 7, 0, 255));
            end
      3'd1: begin
              r = (a << 8) & ~64'h000000ff000000ff;
              for (int i = 0; i < 2; i++) begin
                int w = b[i*32 +: 32];
                longint s = w;
                r[i*32 +: 8] = 8'(clampL((s <<< sc) >>> 23, 0, 255));
              end
            end
      3'd2: for (int i = 0; i < 2; i++) begin
              int w = b[i*32 +: 32];
              longint s = w;
              r[i*16 +: 16] = 16'(clampL((s <<< sc) >>> 16, -32768, 32767));
            end
      3'd3: for (int i = 0; i < 4; i++) r[i*16 +: 16] = {8'd0, b[i*8 +: 8]} << 4;
      3'd4: for (int k = 0; k < 4; k++) begin
              r[k*16 +: 8]     = b[k*8 +: 8];
              r[k*16 + 8 +: 8] = a[k*8 +: 8];
            end
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string opTag(logic [2:0] op);
    case (op)
      3'd0: return "R4"; 3'd1: return "R5"; 3'd2: return "R6";
      3'd3: return "R7"; 3'd4: return "R8"; default: return "R9";
    endcase
  endfunction

  logic [2:0] lastOp = 0;

  task automatic compareNow(string rtag);
    vectors++;
    if (validOut !== expValid || illegalOp !== expIll) begin
      miscompares++;
      $display("FAIL %s: valid/illegal got %b/%b expected %b/%b", (rtag == "") ? "R2" : rtag,
               validOut, illegalOp, expValid, expIll);
    end
    if (result !== expRes) begin
      miscompares++;
      $display("FAIL %s: result got %h expected %h", (rtag == "") ? opTag(lastOp) : rtag, result, expRes);
    end
  endtask

  task automatic step(logic v, logic [2:0] op, logic [4:0] sc, logic [63:0] a, logic [63:0] b, string t);
    @(negedge clk);
    compareNow(tag);
    tag = t;
    validIn = v; opSel = op; scaleIn = sc; srcA = a; srcB = b;
    expValid = v;
    expIll = v && (op > 3'd4);
    if (v) begin
      expRes = model(op, a, b, sc);
      lastOp = op;
    end
  endtask

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareNow("R1");
    validIn = 1; opSel = 3'd4; srcA = '1; srcB = '1;
    @(negedge clk);
    compareNow("R1");
    validIn = 0;
    rstN = 1;
    // R4 boundaries: 255<<7 exact, just above, negative
    step(1, 3'd0, 5'd0, 0, 64'h8000_7f80_7fff_0080, "R4");
    // R3: scale bit 4 ignored by pack16 (scale 17 acts as 1)
    step(1, 3'd0, 5'd17, 0, 64'h0040_0080_ffff_00c0, "R3");
    // R3: status low bits not part of field, bit4 used by pack32
    step(1, 3'd1, 5'd16, 64'h0123_4567_89ab_cdef, 64'h0000_0080_ffff_ff00, "R3");
    // R5
    step(1, 3'd1, 5'd0, 64'hdead_beef_cafe_f00d, 64'h7f80_0000_0000_8000, "R5");
    // R6 saturation
    step(1, 3'd2, 5'd0, 0, 64'h7fff_ffff_8000_0000, "R6");
    step(1, 3'd2, 5'd4, 0, 64'h0000_1234_ffff_f000, "R6");
    // R10: max scale, tiny positive and negative lanes
    step(1, 3'd1, 5'd31, 0, 64'h0000_0001_ffff_ffff, "R10");
    step(1, 3'd2, 5'd31, 0, 64'h0000_0001_ffff_ffff, "R10");
    step(1, 3'd0, 5'd15, 0, 64'h0001_ffff_0000_0002, "R10");
    // R7, R8
    step(1, 3'd3, 5'd9, '1, 64'h0000_0000_ff80_0102, "R7");
    step(1, 3'd4, 5'd0, 64'h1122_3344_5566_7788, 64'h99aa_bbcc_ddee_ff00, "R8");
    // R9 illegal codes
    step(1, 3'd5, 5'd0, '1, '1, "R9");
    step(1, 3'd7, 5'd3, '1, '1, "R9");
    // R2: hold with validIn low, and illegal code ignored when not valid
    step(0, 3'd6, 5'd0, '1, '1, "R2");
    step(0, 3'd4, 5'd0, '1, '1, "R2");
    step(1, 3'd4, 5'd0, 64'h5a, 64'ha5, "R2");
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      step(($urandom_range(0, 3) != 0), op, 5'($urandom), {$urandom, $urandom},
           {$urandom, $urandom}, "");
    end
    step(0, 3'd0, 5'd0, 0, 0, "");
    @(negedge clk);
    compareNow("");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule